// File: doc/BRIEF.md
# Addressable I2C Slave with Mask or Dual-Address Matching

This block is the target side of an I2C-compatible link, placed behind a small register port that a local host reads and writes. SCL and SDA are sampled through a two-flop synchronizer and their edges are found in the system clock domain. The block finds START and STOP conditions and collects the address byte. It acknowledges a matching address and then moves data bytes in either direction. While it waits for the host, it keeps SCL low. The pads are not part of this block: the two outputs request that SCL or SDA be pulled low, and the board-level open-drain wiring does the rest.

Address matching compares against a primary 7-bit address. A second register changes what matching means, chosen by its bit 0. With bit 0 clear, its upper seven bits act as a don't-care mask over the primary address. With bit 0 set, they form a second complete address, and either address is accepted. After every address or data byte the block raises a flag and holds the clock low. The host then services the data register and releases the bus. It can do this with a release command, or, in smart mode, by the data-register access alone. In smart mode a read of a received byte also sends the acknowledge or not-acknowledge chosen in the control register.

Top module: `i2cs_top`

## Requirements
- R1: After reset every register reads 0 and neither SCL nor SDA is pulled low. The registers are: 0 control, 1 primary address (bits 7:1), 2 second address or mask (bits 7:1 plus mode bit 0), 3 data, 4 status.
- R2: With bit 0 of register 2 clear, an incoming address matches when it differs from the primary address only in bit positions where register 2 bits 7:1 hold a 1.
- R3: With bit 0 of register 2 set, an address matches only when it equals the primary address or register 2 bits 7:1 exactly. Masking no longer applies.
- R4: A non-matching address gets no acknowledge. SDA is never pulled low, no flag is set and the data register is untouched until the next START.
- R5: A matching address is acknowledged by pulling SDA low during the ninth clock. After that clock falls, status bit 3 (address flag) and bit 1 (hold flag) are set and SCL is held low. Status bit 2 shows the received R/W bit, where 1 means the master reads.
- R6: On a master write, the eighth falling SCL edge of a data byte places the byte in register 3. It also sets status bit 0 (data flag) and the hold flag, and SCL is held low.
- R7: Writing register 4 with bit 0 set clears the data, hold and address flags and frees SCL. A pending received byte is then answered with ACK when control bit 0 is 0, or with NACK when it is 1.
- R8: On a master read, register 3 is sent MSB first. After a master ACK, the data and hold flags are set on the falling edge that ends the ACK bit. After a master NACK, only the data flag is set, SCL stays free and the block returns to idle.
- R9: With control bit 1 (smart mode) set, any read or write of register 3 clears the data and hold flags and frees SCL. A read of a received byte also sends ACK or NACK according to control bit 0. A write loads the next byte to send.
- R10: A START aborts any transfer and restarts address reception. A STOP returns the block to idle. Both clear the hold flag, and a byte cut short never reaches register 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_low_o | output | 1 | Request to pull SCL low (clock stretch) |
| sda_low_o | output | 1 | Request to pull SDA low |
| reg_addr | input | 3 | Host register index |
| reg_wr | input | 1 | Host write strobe, one cycle |
| reg_rd | input | 1 | Host read strobe, one cycle |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, combinational from the index |

## Verification
A wrong match decision shows on the bus within the same byte. The ninth clock either carries an acknowledge it should not, or lacks one it should. A second symptom follows a few system cycles after that clock falls: SCL is held low when it should not be, or left free when it should be held. A corrupted bit count or shift register shows up as a wrong byte in the data register, or on SDA during a master read, as soon as the host services the flag. A stuck hold flag leaves SCL low, and the master then stalls at its next rising edge. A lost release path shows the same stall. Faults in the acknowledge choice appear as the wrong level on SDA in the ninth clock that immediately follows the host access.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int RA_W = 3;

    localparam logic [RA_W-1:0] RG_CTRL = RA_W'(0);
    localparam logic [RA_W-1:0] RG_OWN  = RA_W'(1);
    localparam logic [RA_W-1:0] RG_ALT  = RA_W'(2);
    localparam logic [RA_W-1:0] RG_DATA = RA_W'(3);
    localparam logic [RA_W-1:0] RG_STAT = RA_W'(4);

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_ADDR  = 4'd1,
        ST_AACK  = 4'd2,
        ST_AHOLD = 4'd3,
        ST_RX    = 4'd4,
        ST_RHOLD = 4'd5,
        ST_RACK  = 4'd6,
        ST_TX    = 4'd7,
        ST_TACK  = 4'd8,
        ST_THOLD = 4'd9
    } state_e;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_d, chain_q;
    logic              prev_d, prev_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
        prev_d  = chain_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
            prev_q  <= RST_VAL;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign level = chain_q[STAGES-1];
    assign rise  = level & ~prev_q;
    assign fall  = ~level & prev_q;

endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match #(
    parameter int AW = 7
) (
    input  logic [AW-1:0] rx_addr,
    input  logic [AW-1:0] own_addr,
    input  logic [AW-1:0] alt_addr,
    input  logic          dual_mode,
    output logic          hit
);
    logic [AW-1:0] bit_ok;

    for (genvar i = 0; i < AW; i++) begin : g_bit
        assign bit_ok[i] = (rx_addr[i] == own_addr[i]) | alt_addr[i];
    end

    always_comb begin
        if (dual_mode) hit = (rx_addr == own_addr) || (rx_addr == alt_addr);
        else           hit = &bit_ok;
    end

endmodule

// File: rtl/i2cs_top.sv
module i2cs_top
    import i2cs_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_low_o,
    output logic              sda_low_o,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W:0]   reg_wdata,
    output logic [ADDR_W:0]   reg_rdata
);
    localparam int BW = ADDR_W + 1;
    localparam int CW = $clog2(BW + 1);

    typedef struct packed {
        state_e            st;
        logic [CW-1:0]     cnt;
        logic [BW-1:0]     sh;
        logic [BW-1:0]     data;
        logic [ADDR_W-1:0] own;
        logic [ADDR_W-1:0] alt;
        logic              dual;
        logic              smart;
        logic              nack_sel;
        logic              dif;
        logic              hold;
        logic              aif;
        logic              dir;
        logic              mack;
        logic              nack_act;
        logic              stretch;
    } regs_t;

    regs_t d, q;

    logic scl_lv, scl_rise, scl_fall;
    logic sda_lv, sda_rise, sda_fall;
    logic hit, start_det, stop_det, data_acc, release_ev;
    logic [BW-1:0] tx_sh;

    i2cs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_scl (
        .clk(clk), .rst_n(rst_n), .din(scl_i),
        .level(scl_lv), .rise(scl_rise), .fall(scl_fall)
    );

    i2cs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_sda (
        .clk(clk), .rst_n(rst_n), .din(sda_i),
        .level(sda_lv), .rise(sda_rise), .fall(sda_fall)
    );

    i2cs_addr_match #(.AW(ADDR_W)) i_match (
        .rx_addr(q.sh[BW-1:1]), .own_addr(q.own), .alt_addr(q.alt),
        .dual_mode(q.dual), .hit(hit)
    );

    assign start_det  = sda_fall & scl_lv & ~scl_rise;
    assign stop_det   = sda_rise & scl_lv & ~scl_rise;
    assign data_acc   = (reg_wr | reg_rd) && (reg_addr == RG_DATA);
    assign release_ev = (reg_wr && reg_addr == RG_STAT && reg_wdata[0]) || (q.smart && data_acc);
    assign tx_sh      = q.data << q.cnt;

    always_comb begin
        d = q;
        d.stretch = q.hold;

        if (reg_wr) begin
            case (reg_addr)
                RG_CTRL: {d.smart, d.nack_sel} = reg_wdata[1:0];
                RG_OWN:  d.own = reg_wdata[BW-1:1];
                RG_ALT:  {d.alt, d.dual} = reg_wdata;
                RG_DATA: d.data = reg_wdata;
                default: ;
            endcase
        end

        if (release_ev) begin
            d.dif  = 1'b0;
            d.hold = 1'b0;
            d.aif  = 1'b0;
        end

        case (q.st)
            ST_ADDR: begin
                if (scl_rise && q.cnt != CW'(BW)) begin
                    d.sh  = {q.sh[BW-2:0], sda_lv};
                    d.cnt = q.cnt + CW'(1);
                end else if (scl_fall && q.cnt == CW'(BW)) begin
                    d.cnt = '0;
                    d.dir = q.sh[0];
                    d.st  = hit ? ST_AACK : ST_IDLE;
                end
            end
            ST_AACK: if (scl_fall) begin
                d.st   = ST_AHOLD;
                d.hold = 1'b1;
                d.aif  = 1'b1;
            end
            ST_AHOLD: if (release_ev) begin
                d.st  = q.dir ? ST_TX : ST_RX;
                d.cnt = '0;
            end
            ST_RX: begin
                if (scl_rise && q.cnt != CW'(BW)) begin
                    d.sh  = {q.sh[BW-2:0], sda_lv};
                    d.cnt = q.cnt + CW'(1);
                end else if (scl_fall && q.cnt == CW'(BW)) begin
                    d.data = q.sh;
                    d.dif  = 1'b1;
                    d.hold = 1'b1;
                    d.cnt  = '0;
                    d.st   = ST_RHOLD;
                end
            end
            ST_RHOLD: if (release_ev) begin
                d.st       = ST_RACK;
                d.nack_act = q.nack_sel;
            end
            ST_RACK: if (scl_fall) begin
                d.cnt = '0;
                d.st  = q.nack_act ? ST_IDLE : ST_RX;
            end
            ST_TX: if (scl_fall) begin
                if (q.cnt == CW'(BW - 1)) begin
                    d.cnt = '0;
                    d.st  = ST_TACK;
                end else begin
                    d.cnt = q.cnt + CW'(1);
                end
            end
            ST_TACK: begin
                if (scl_rise) d.mack = ~sda_lv;
                if (scl_fall) begin
                    d.dif = 1'b1;
                    if (q.mack) begin
                        d.hold = 1'b1;
                        d.st   = ST_THOLD;
                    end else begin
                        d.st = ST_IDLE;
                    end
                end
            end
            ST_THOLD: if (release_ev) begin
                d.st  = ST_TX;
                d.cnt = '0;
            end
            default: ;
        endcase

        if (start_det) begin
            d.st   = ST_ADDR;
            d.cnt  = '0;
            d.hold = 1'b0;
            d.aif  = 1'b0;
        end else if (stop_det) begin
            d.st   = ST_IDLE;
            d.cnt  = '0;
            d.hold = 1'b0;
            d.aif  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign scl_low_o = q.stretch;
    assign sda_low_o = (q.st == ST_AACK)
                     | (q.st == ST_RACK && !q.nack_act)
                     | (q.st == ST_TX && !tx_sh[BW-1]);

    always_comb begin
        case (reg_addr)
            RG_CTRL: reg_rdata = {{(BW-2){1'b0}}, q.smart, q.nack_sel};
            RG_OWN:  reg_rdata = {q.own, 1'b0};
            RG_ALT:  reg_rdata = {q.alt, q.dual};
            RG_DATA: reg_rdata = q.data;
            RG_STAT: reg_rdata = {{(BW-4){1'b0}}, q.aif, q.dir, q.hold, q.dif};
            default: reg_rdata = '0;
        endcase
    end

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (q.st == ST_IDLE && !q.hold)); // R10

    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (q.st == ST_ADDR && q.cnt == '0 && !q.hold)); // R10

    AST_MISS_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ADDR && scl_fall && q.cnt == CW'(BW) && !hit) |=> (!sda_low_o && q.st == ST_IDLE)); // R4

    AST_HOLD_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        q.hold |-> (q.st inside {ST_AHOLD, ST_RHOLD, ST_THOLD})); // R5

    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (q.hold && release_ev && !start_det && !stop_det) |=> (!q.hold && !q.dif && !q.aif)); // R7

    AST_FULL_MASK_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.dual && (&q.alt) && q.st == ST_ADDR && scl_fall && q.cnt == CW'(BW)) |=> (q.st == ST_AACK)); // R2

endmodule

// File: tb/test_i2cs_top.sv
`timescale 1ns/1ps
module test_i2cs_top;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n;
    logic       scl_m, sda_m;
    logic       scl_low, sda_low;
    logic       scl_line, sda_line;
    logic [2:0] ra;
    logic       rwr, rrd;
    logic [7:0] rwd, rdat;

    assign scl_line = scl_m & ~scl_low;
    assign sda_line = sda_m & ~sda_low;

    i2cs_top i_i2cs_top (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_low_o(scl_low), .sda_low_o(sda_low),
        .reg_addr(ra), .reg_wr(rwr), .reg_rd(rrd),
        .reg_wdata(rwd), .reg_rdata(rdat)
    );

    int total = 0;
    int bad   = 0;

    logic [7:0] rx_exp[$];
    logic [7:0] tx_src[$];
    bit         smart   = 1'b0;
    bit         svc_en  = 1'b0;
    bit         exp_dir = 1'b0;

    bit         req_w;
    logic [2:0] req_a;
    logic [7:0] req_d;
    logic [7:0] res;
    int         req_id = 0;
    int         ack_id = 0;

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // host port driver: only the process below touches the register strobes
    task automatic acc(bit w, logic [2:0] a, logic [7:0] dv, output logic [7:0] r);
        @(negedge clk);
        ra = a; rwd = dv; rwr = w; rrd = !w;
        #1 r = rdat;
        @(negedge clk);
        rwr = 1'b0; rrd = 1'b0;
    endtask

    task automatic load_tx();
        logic [7:0] dv, junk;
        dv = (tx_src.size() != 0) ? tx_src.pop_front() : 8'hFF;
        acc(1'b1, 3'd3, dv, junk);
        if (!smart) acc(1'b1, 3'd4, 8'h01, junk);
    endtask

    // scoreboard monitor: services each stretch and compares received bytes
    task automatic service();
        logic [7:0] st, dv, junk;
        acc(1'b0, 3'd4, 8'h00, st);
        if (st[3]) begin
            chk("R5", "direction bit on address flag", st[2], exp_dir);
            if (st[2]) load_tx();
            else acc(1'b1, 3'd4, 8'h01, junk);
        end else if (st[0]) begin
            if (!st[2]) begin
                acc(1'b0, 3'd3, 8'h00, dv);
                if (rx_exp.size() == 0) chk("R6", "unexpected received byte", 1, 0);
                else chk("R6", "received byte", dv, rx_exp.pop_front());
                if (!smart) acc(1'b1, 3'd4, 8'h01, junk);
                else begin
                    acc(1'b0, 3'd4, 8'h00, st);
                    chk("R9", "flags after smart data read", st[1:0], 0);
                end
            end else begin
                load_tx();
            end
        end else begin
            chk("R5", "stretch without a flag", 0, 1);
            acc(1'b1, 3'd4, 8'h01, junk);
        end
        wait (scl_low == 1'b0);
    endtask

    initial begin
        logic [7:0] r;
        ra = '0; rwd = '0; rwr = 1'b0; rrd = 1'b0;
        forever begin
            @(negedge clk);
            if (req_id != ack_id) begin
                acc(req_w, req_a, req_d, r);
                res = r;
                ack_id = req_id;
            end else if (svc_en && scl_low) begin
                service();
            end
        end
    end

    task automatic h_op(bit w, logic [2:0] a, logic [7:0] dv, output logic [7:0] r);
        req_w = w; req_a = a; req_d = dv;
        req_id++;
        wait (ack_id == req_id);
        r = res;
    endtask

    task automatic hw(logic [2:0] a, logic [7:0] dv);
        logic [7:0] junk;
        h_op(1'b1, a, dv, junk);
    endtask

    // bus master
    task automatic tq();
        repeat (8) @(negedge clk);
    endtask

    task automatic wait_high();
        while (!scl_line) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; scl_m = 1'b1; tq();
        sda_m = 1'b0; tq();
        scl_m = 1'b0; tq();
    endtask

    task automatic m_rstart();
        sda_m = 1'b1; tq();
        scl_m = 1'b1; wait_high(); tq();
        sda_m = 1'b0; tq();
        scl_m = 1'b0; tq();
    endtask

    task automatic m_stop();
        sda_m = 1'b0; tq();
        scl_m = 1'b1; wait_high(); tq();
        sda_m = 1'b1; tq();
    endtask

    task automatic m_bit(bit b);
        sda_m = b; tq();
        scl_m = 1'b1; wait_high(); tq();
        scl_m = 1'b0; tq();
    endtask

    task automatic m_rbit(output bit b);
        sda_m = 1'b1; tq();
        scl_m = 1'b1; wait_high(); tq();
        b = sda_line;
        scl_m = 1'b0; tq();
    endtask

    task automatic m_wbyte(logic [7:0] dv, output bit ack_n);
        for (int i = 7; i >= 0; i--) m_bit(dv[i]);
        m_rbit(ack_n);
    endtask

    task automatic m_rbyte(output logic [7:0] dv, input bit ack_n);
        bit b;
        for (int i = 7; i >= 0; i--) begin
            m_rbit(b);
            dv[i] = b;
        end
        m_bit(ack_n);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        bit a;
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1", "scl pull", scl_low, 0);
        chk("R1", "sda pull", sda_low, 0);
        for (int i = 0; i < 5; i++) begin
            h_op(1'b0, 3'(i), 8'h00, r);
            chk("R1", $sformatf("register %0d", i), r, 0);
        end

        hw(3'd1, 8'h54);
        svc_en = 1'b1;

        // R5 R6 R7 master write, plain matching
        exp_dir = 1'b0;
        rx_exp.push_back(8'hA5); rx_exp.push_back(8'h3C);
        m_start();
        m_wbyte(8'h54, a); chk("R5", "address ack", a, 0);
        m_wbyte(8'hA5, a); chk("R7", "ack first byte", a, 0);
        m_wbyte(8'h3C, a); chk("R7", "ack second byte", a, 0);
        m_stop();
        chk("R6", "bytes left unconsumed", rx_exp.size(), 0);
        h_op(1'b0, 3'd3, 8'h00, r); chk("R6", "last byte in data register", r, 8'h3C);

        // R4 address miss
        m_start();
        m_wbyte(8'h56, a); chk("R4", "no ack on miss", a, 1);
        m_wbyte(8'h00, a); chk("R4", "no ack after miss", a, 1);
        m_stop();
        h_op(1'b0, 3'd3, 8'h00, r); chk("R4", "data register untouched", r, 8'h3C);
        h_op(1'b0, 3'd4, 8'h00, r); chk("R4", "no flags after miss", r, 0);

        // R2 mask mode: mask bits 1:0
        hw(3'd2, 8'h06);
        rx_exp.push_back(8'h11);
        m_start();
        m_wbyte({7'h29, 1'b0}, a); chk("R2", "masked bits ignored", a, 0);
        m_wbyte(8'h11, a); chk("R2", "byte after masked match", a, 0);
        m_stop();
        m_start();
        m_wbyte({7'h2E, 1'b0}, a); chk("R2", "unmasked bit differs", a, 1);
        m_stop();

        // R3 dual address
        hw(3'd2, 8'h23);
        rx_exp.push_back(8'h77);
        m_start();
        m_wbyte({7'h11, 1'b0}, a); chk("R3", "second address", a, 0);
        m_wbyte(8'h77, a); chk("R3", "byte to second address", a, 0);
        m_stop();
        m_start();
        m_wbyte({7'h29, 1'b0}, a); chk("R3", "mask off in dual mode", a, 1);
        m_stop();
        m_start();
        m_wbyte({7'h2A, 1'b0}, a); chk("R3", "primary in dual mode", a, 0);
        m_stop();
        chk("R6", "bytes left unconsumed", rx_exp.size(), 0);

        // R7 NACK selection
        hw(3'd0, 8'h01);
        rx_exp.push_back(8'h5A);
        m_start();
        m_wbyte(8'h54, a); chk("R7", "address ack", a, 0);
        m_wbyte(8'h5A, a); chk("R7", "nack chosen by control bit 0", a, 1);
        m_stop();
        hw(3'd0, 8'h00);

        // R8 master read
        exp_dir = 1'b1;
        tx_src.push_back(8'h96); tx_src.push_back(8'h0F);
        m_start();
        m_wbyte(8'h55, a); chk("R5", "read address ack", a, 0);
        m_rbyte(r, 1'b0); chk("R8", "first read byte", r, 8'h96);
        m_rbyte(r, 1'b1); chk("R8", "second read byte", r, 8'h0F);
        m_stop();
        chk("R8", "scl free after master nack", scl_low, 0);
        h_op(1'b0, 3'd4, 8'h00, r); chk("R8", "data flag only after nack", r[1:0], 2'b01);
        hw(3'd4, 8'h01);
        h_op(1'b0, 3'd4, 8'h00, r); chk("R7", "command clears flags", r, 8'h04);

        // R9 smart mode
        smart = 1'b1;
        hw(3'd0, 8'h02);
        exp_dir = 1'b0;
        rx_exp.push_back(8'hC3); rx_exp.push_back(8'h81);
        m_start();
        m_wbyte(8'h54, a); chk("R9", "address ack", a, 0);
        m_wbyte(8'hC3, a); chk("R9", "smart read gives ack", a, 0);
        m_wbyte(8'h81, a); chk("R9", "smart read gives ack", a, 0);
        m_stop();
        exp_dir = 1'b1;
        tx_src.push_back(8'hE7);
        m_start();
        m_wbyte(8'h55, a); chk("R9", "read address ack", a, 0);
        m_rbyte(r, 1'b1); chk("R9", "byte loaded by smart write", r, 8'hE7);
        m_stop();
        h_op(1'b0, 3'd4, 8'h00, r); chk("R9", "flag set before access", r[0], 1);
        h_op(1'b0, 3'd3, 8'h00, r);
        h_op(1'b0, 3'd4, 8'h00, r); chk("R9", "data access clears flag", r[1:0], 0);
        hw(3'd0, 8'h03);
        exp_dir = 1'b0;
        rx_exp.push_back(8'h44);
        m_start();
        m_wbyte(8'h54, a); chk("R9", "address ack", a, 0);
        m_wbyte(8'h44, a); chk("R9", "smart read gives nack", a, 1);
        m_stop();
        hw(3'd0, 8'h00);
        smart = 1'b0;

        // R10 abort by STOP and repeated START
        m_start();
        m_wbyte(8'h54, a); chk("R10", "address ack", a, 0);
        m_bit(1'b1); m_bit(1'b0); m_bit(1'b1);
        m_stop();
        chk("R10", "scl free after stop", scl_low, 0);
        h_op(1'b0, 3'd3, 8'h00, r); chk("R10", "cut byte not stored", r, 8'h44);
        h_op(1'b0, 3'd4, 8'h00, r); chk("R10", "no flags after stop", r[1:0], 0);
        rx_exp.push_back(8'h99);
        m_start();
        m_wbyte(8'h54, a); chk("R10", "address ack", a, 0);
        m_bit(1'b0); m_bit(1'b1); m_bit(1'b1); m_bit(1'b0);
        m_rstart();
        m_wbyte(8'h54, a); chk("R10", "address after repeated start", a, 0);
        m_wbyte(8'h99, a); chk("R10", "byte after repeated start", a, 0);
        m_stop();
        chk("R10", "bytes left unconsumed", rx_exp.size(), 0);

        repeat (20) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule